// File: doc/BRIEF.md
# Byte-Wide Parallel Configuration Loader

This block sits on the host side of an FPGA configuration link and streams a configuration image into an 8-bit parallel slave port. Bytes arrive on a valid/ready input stream with a last flag. Each accepted byte is placed on an 8-bit data bus for exactly one period of a generated configuration clock. The block also drives active-low chip-select and write strobes that frame the transfer. Byte-wide operation is the default and the only width supported.

The target's pins follow a reversed bit convention: pin D0 carries the most significant bit of each byte and pin D7 the least significant. When the stored image is in conventional order, the per-byte swap input maps it onto that convention. When the image has already been bit-swapped, the swap input is held low and bytes reach the pins unchanged.

The block watches the bytes it has sent for the 32-bit synchronization word 0xAA995566. When that word has been clocked out, it raises a sticky flag marking the start of configuration. A done flag reports that a stream's final byte has left the port.

Top module: `cfg_byte_loader`

## Requirements
- R1: After a byte is accepted, it is presented for exactly CLK_DIV system cycles. `cfg_cclk` is low for the first CLK_DIV/2 of those cycles and high for the rest, giving one rising edge per byte.
- R2: With `in_swap` high at acceptance, `cfg_d[i]` equals bit 7-i of the byte, so pin D0 (`cfg_d[0]`) carries the MSB. For example, 0xAB appears as 0xD5 and 0xCD as 0xB3. A change of `in_swap` after acceptance has no effect on the byte being presented.
- R3: With `in_swap` low at acceptance, `cfg_d` equals the byte unchanged (for example 0x12 appears as 0x12).
- R4: `in_ready` is low while a byte is presented, except in the final cycle of a slot whose byte is not flagged last. It is high when no byte is presented. Every accepted byte appears on the bus exactly once, in order, under any back-pressure pattern.
- R5: `cfg_d` changes only in the cycle after a byte is accepted, where `cfg_cclk` is low. It is stable across every rising `cfg_cclk` edge.
- R6: `cfg_cs_n` and `cfg_wr_n` fall together in the cycle after the first byte of a stream is accepted. They rise together in the cycle after the last-flagged byte's slot ends. `busy` is high exactly while the strobes are low.
- R7: `done` rises in the cycle the strobes rise after a last-flagged byte. It stays high until the next stream's first byte is accepted.
- R8: `sync_seen` rises one cycle after the slot of the byte that completes 0xAA, 0x99, 0x55, 0x66 as the last four stored bytes of the current stream, compared in pre-swap order whatever `in_swap` is. It is sticky within the stream and cleared when a new stream starts. A sequence split across two streams does not match.
- R9: During and after reset: `in_ready`=1, `cfg_cs_n`=1, `cfg_wr_n`=1, `cfg_cclk`=0, `cfg_d`=0x00, `busy`=0, `done`=0, `sync_seen`=0.
- R10: `cfg_cclk` stays low whenever no byte is presented, including while the strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Loader can take a byte this cycle |
| in_data | input | 8 | Image byte in stored order |
| in_last | input | 1 | Byte is the last of the stream |
| in_swap | input | 1 | 1: reverse bit order onto the pins; 0: pass unchanged |
| cfg_d | output | 8 | Data bus, `cfg_d[0]` is pin D0 |
| cfg_cclk | output | 1 | Generated configuration clock |
| cfg_cs_n | output | 1 | Active-low chip select |
| cfg_wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Stream in progress |
| done | output | 1 | Last byte of the latest stream has been sent |
| sync_seen | output | 1 | Synchronization word has been sent in this stream |

## Verification
The hardest case to reach from the ports is the boundary where a slot ends and the next byte is accepted on the same edge. Here `in_ready` opens for one cycle only, and only when the current byte is not the last. The bench drives long runs with zero gap, so acceptances land exactly on slot ends. It mixes these with random gaps, so other acceptances land while the loader is idle. A cycle-level reference model then compares the bus, clock and strobes on every cycle. Two further cases need crafted streams: a synchronization word split across two streams, and a word with only its final byte wrong. Both are sent as short streams that must leave `sync_seen` low.

// File: rtl/cfg_loader_pkg.sv
// Package: shared constants and types for the parallel configuration loader.
// Assumes an 8-bit bus; the sync word default is the standard 32-bit value.
package cfg_loader_pkg;
    localparam int          BYTE_W        = 8;
    localparam logic [31:0] SYNC_WORD_DEF = 32'hAA99_5566;

    typedef logic [BYTE_W-1:0] cfg_byte_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } strm_state_e;
endpackage

// File: rtl/cfg_pace.sv
// Module: cfg_pace
// Paces one byte slot of CLK_DIV system cycles and generates the configuration
// clock: low for the first CLK_DIV/2 cycles of a slot, high for the rest.
// Assumes CLK_DIV >= 2 and that load is only raised when the slot is free or ending.
module cfg_pace #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic active,
    output logic slot_end,
    output logic cclk
);
    localparam int PH_W    = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int LOW_CYC = CLK_DIV / 2;
    localparam int PH_LAST = CLK_DIV - 1;

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_nxt;
    logic            act_q;
    logic            cclk_q;

    // Next phase value within the slot.
    always_comb begin
        ph_nxt = ph_q + 1'b1;
    end

    assign active   = act_q;
    assign slot_end = act_q && (ph_q == PH_W'(PH_LAST));
    assign cclk     = cclk_q;

    // Slot phase counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            act_q  <= 1'b0;
            cclk_q <= 1'b0;
        end else if (load) begin
            ph_q   <= '0;
            act_q  <= 1'b1;
            cclk_q <= 1'b0;
        end else if (slot_end) begin
            ph_q   <= '0;
            act_q  <= 1'b0;
            cclk_q <= 1'b0;
        end else if (act_q) begin
            ph_q   <= ph_nxt;
            cclk_q <= (ph_nxt >= PH_W'(LOW_CYC));
        end
    end

    // R1: the clock rises only at the mid-slot phase of an active slot.
    a_r1_rise_mid_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_q) |-> (act_q && ph_q == PH_W'(LOW_CYC)));

    // R10: no clock activity without a byte in the slot.
    a_r10_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q |-> !cclk_q);
endmodule

// File: rtl/cfg_byte_path.sv
// Module: cfg_byte_path
// Registers the presented byte, optionally reversing its bit order so that
// bus bit 0 (pin D0) carries the stored MSB. Keeps the stored byte for sync checks.
// Assumes swap_en is only meaningful in the load cycle.
module cfg_byte_path
    import cfg_loader_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      swap_en,
    input  cfg_byte_t byte_in,
    output cfg_byte_t bus_d,
    output cfg_byte_t raw_d
);
    cfg_byte_t mapped;
    cfg_byte_t bus_q;
    cfg_byte_t raw_q;

    // Per-bit swap mux: reversed when swap_en, straight otherwise.
    for (genvar i = 0; i < BYTE_W; i++) begin : g_swap
        assign mapped[i] = swap_en ? byte_in[BYTE_W-1-i] : byte_in[i];
    end

    // Capture both pin-order and stored-order copies on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0;
            raw_q <= '0;
        end else if (load) begin
            bus_q <= mapped;
            raw_q <= byte_in;
        end
    end

    assign bus_d = bus_q;
    assign raw_d = raw_q;

    // R2: the reversed pin byte always mirrors the stored byte when swapping.
    a_r2_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (load && swap_en) |=> (bus_q[0] == raw_q[BYTE_W-1] && bus_q[BYTE_W-1] == raw_q[0]));

    // R3: without swapping the pins carry the stored byte.
    a_r3_straight: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !swap_en) |=> (bus_q == raw_q));
endmodule

// File: rtl/cfg_sync_detect.sv
// Module: cfg_sync_detect
// Tracks the last four stored bytes sent in the current stream and raises a
// sticky flag once they equal SYNC_WORD (first byte most significant).
// Assumes clear and shift are never raised together.
module cfg_sync_detect
    import cfg_loader_pkg::*;
#(
    parameter logic [31:0] SYNC_WORD = SYNC_WORD_DEF
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic      shift,
    input  cfg_byte_t byte_in,
    output logic      seen
);
    localparam int NB     = 32 / BYTE_W;
    localparam int FILL_W = $clog2(NB + 1);

    logic [31:0]       win_q;
    logic [31:0]       win_nxt;
    logic [FILL_W-1:0] fill_q;
    logic              seen_q;
    logic              hit;

    // Window after taking in the byte just sent.
    always_comb begin
        win_nxt = {win_q[31-BYTE_W:0], byte_in};
        hit     = (fill_q >= FILL_W'(NB - 1)) && (win_nxt == SYNC_WORD);
    end

    // Window, fill count and sticky match flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            win_q  <= '0;
            fill_q <= '0;
            seen_q <= 1'b0;
        end else if (shift) begin
            win_q <= win_nxt;
            if (fill_q != FILL_W'(NB)) begin
                fill_q <= fill_q + 1'b1;
            end
            if (hit) begin
                seen_q <= 1'b1;
            end
        end
    end

    assign seen = seen_q;

    // R8: the flag holds until a new stream clears it.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !clear) |=> seen_q);

    // R8: the flag only rises right after a byte has been sent.
    a_r8_rise_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seen_q) |-> $past(shift));
endmodule

// File: rtl/cfg_byte_loader.sv
// Module: cfg_byte_loader (top)
// Streams bytes from a valid/ready input onto an 8-bit configuration port,
// one byte per generated clock period, framed by active-low chip-select and
// write strobes, with optional bit reversal and sync-word detection.
// Assumes CLK_DIV >= 2; a new stream starts only after the strobes are released.
module cfg_byte_loader
    import cfg_loader_pkg::*;
#(
    parameter int          CLK_DIV   = 4,
    parameter logic [31:0] SYNC_WORD = SYNC_WORD_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_swap,
    output logic [7:0] cfg_d,
    output logic       cfg_cclk,
    output logic       cfg_cs_n,
    output logic       cfg_wr_n,
    output logic       busy,
    output logic       done,
    output logic       sync_seen
);
    strm_state_e st_q;
    logic        last_q;
    logic        done_q;
    logic        active;
    logic        slot_end;
    logic        load;
    logic        start;
    logic        finish;
    cfg_byte_t   raw_d;

    // Handshake: open when idle, or on a non-final slot's last cycle.
    always_comb begin
        in_ready = !active || (slot_end && !last_q);
        load     = in_valid && in_ready;
        start    = load && (st_q == ST_IDLE);
        finish   = slot_end && last_q;
    end

    cfg_pace #(
        .CLK_DIV (CLK_DIV)
    ) u_pace (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .active   (active),
        .slot_end (slot_end),
        .cclk     (cfg_cclk)
    );

    cfg_byte_path u_path (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .swap_en (in_swap),
        .byte_in (in_data),
        .bus_d   (cfg_d),
        .raw_d   (raw_d)
    );

    cfg_sync_detect #(
        .SYNC_WORD (SYNC_WORD)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .shift   (slot_end),
        .byte_in (raw_d),
        .seen    (sync_seen)
    );

    // Stream framing, last-byte marker and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            last_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (load) begin
                last_q <= in_last;
            end
            if (start) begin
                st_q   <= ST_STREAM;
                done_q <= 1'b0;
            end else if (finish) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
            end
        end
    end

    assign cfg_cs_n = (st_q == ST_IDLE);
    assign cfg_wr_n = (st_q == ST_IDLE);
    assign busy     = (st_q == ST_STREAM);
    assign done     = done_q;

    // R5: data never moves across a rising configuration clock edge.
    a_r5_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_cclk) |-> $stable(cfg_d));

    // R4: a byte held mid-slot is not replaced.
    a_r4_hold_mid_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !slot_end) |=> $stable(cfg_d));

    // R10: no clock while the strobes are released.
    a_r10_no_clock_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cs_n |-> !cfg_cclk);

    // R7: completion is only reported with the strobes released.
    a_r7_done_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cfg_cs_n);

    // R6: strobes release only as a final slot ends.
    a_r6_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_cs_n) |-> $past(slot_end && last_q));
endmodule

// File: tb/test_cfg_byte_loader.sv
// Bench: behavioural cycle model compared against the loader on every clock,
// plus a scoreboard of bytes seen at each rising configuration clock edge.
module test_cfg_byte_loader;
    localparam int DIV = 4;
    localparam int LOW = DIV / 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] in_data;
    logic       in_last;
    logic       in_swap;
    logic [7:0] cfg_d;
    logic       cfg_cclk;
    logic       cfg_cs_n;
    logic       cfg_wr_n;
    logic       busy;
    logic       done;
    logic       sync_seen;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cfg_byte_loader #(.CLK_DIV(DIV)) i_cfg_byte_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_swap   (in_swap),
        .cfg_d     (cfg_d),
        .cfg_cclk  (cfg_cclk),
        .cfg_cs_n  (cfg_cs_n),
        .cfg_wr_n  (cfg_wr_n),
        .busy      (busy),
        .done      (done),
        .sync_seen (sync_seen)
    );

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7 - i];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model state.
    int         m_ph;
    bit         m_act, m_cclk, m_csn, m_done, m_sync, m_last;
    logic [7:0] m_d, m_raw;
    logic [7:0] sent[$];
    logic [7:0] exp_q[$];
    bit         swp_q[$];
    logic [7:0] captured[$];
    bit         m_acc, m_fin;

    function automatic bit m_ready();
        return !m_act || (m_ph == DIV - 1 && !m_last);
    endfunction

    // Model update on each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_act = 0; m_cclk = 0; m_csn = 1; m_done = 0; m_sync = 0;
            m_last = 0; m_d = 8'h00; m_raw = 8'h00;
            sent.delete();
        end else begin
            m_acc = in_valid && m_ready();
            m_fin = m_act && (m_ph == DIV - 1);
            if (m_fin) begin
                sent.push_back(m_raw);
                if (sent.size() >= 4 && sent[sent.size()-4] == 8'hAA && sent[sent.size()-3] == 8'h99
                    && sent[sent.size()-2] == 8'h55 && sent[sent.size()-1] == 8'h66)
                    m_sync = 1;
                if (m_last) begin
                    m_csn = 1;
                    m_done = 1;
                end
            end
            if (m_acc) begin
                if (m_csn) begin
                    m_csn = 0; m_done = 0; m_sync = 0;
                    sent.delete();
                end
                m_act = 1; m_ph = 0; m_cclk = 0;
                m_raw = in_data;
                m_d = in_swap ? rev8(in_data) : in_data;
                m_last = in_last;
                exp_q.push_back(m_d);
                swp_q.push_back(in_swap);
            end else if (m_fin) begin
                m_act = 0; m_ph = 0; m_cclk = 0;
            end else if (m_act) begin
                m_ph++;
                m_cclk = (m_ph >= LOW);
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    logic prev_cclk = 1'b0;
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            check("R5 cfg_d", cfg_d, m_d);
            check("R1 cfg_cclk", cfg_cclk, m_cclk);
            check("R6 cfg_cs_n", cfg_cs_n, m_csn);
            check("R6 cfg_wr_n", cfg_wr_n, m_csn);
            check("R6 busy", busy, !m_csn);
            check("R7 done", done, m_done);
            check("R8 sync_seen", sync_seen, m_sync);
            check("R4 in_ready", in_ready, m_ready());
            if (cfg_cclk && !prev_cclk) begin
                captured.push_back(cfg_d);
                if (exp_q.size() == 0) begin
                    check("R4 unexpected byte", 1, 0);
                end else begin
                    check(swp_q[0] ? "R2 swapped byte" : "R3 straight byte", cfg_d, exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(swp_q.pop_front());
                end
            end
        end
        prev_cclk = cfg_cclk;
    end

    task automatic send(input logic [7:0] d, input bit last, input bit sw, input int gap);
        bit r;
        repeat (gap) @(negedge clk);
        in_valid = 1'b1; in_data = d; in_last = last; in_swap = sw;
        forever begin
            r = in_ready;
            @(negedge clk);
            if (r) break;
        end
        in_valid = 1'b0; in_data = 8'h5A; in_last = 1'b0; in_swap = !sw;
    endtask

    task automatic wait_idle();
        while (cfg_cs_n !== 1'b1) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0; in_swap = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state.
        check("R9 in_ready", in_ready, 1);
        check("R9 cfg_cs_n", cfg_cs_n, 1);
        check("R9 cfg_wr_n", cfg_wr_n, 1);
        check("R9 cfg_cclk", cfg_cclk, 0);
        check("R9 cfg_d", cfg_d, 0);
        check("R9 busy", busy, 0);
        check("R9 done", done, 0);
        check("R9 sync_seen", sync_seen, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 idle clock low", cfg_cclk, 0);

        // Swapped stream, back to back, with sync word then 0xAB 0xCD.
        captured.delete();
        send(8'hAA, 0, 1, 0); send(8'h99, 0, 1, 0); send(8'h55, 0, 1, 0);
        send(8'h66, 0, 1, 0); send(8'hAB, 0, 1, 0); send(8'hCD, 1, 1, 0);
        wait_idle();
        check("R8 sync after swapped stream", sync_seen, 1);
        check("R7 done after stream", done, 1);
        check("R2 0xAB on pins", captured[4], 8'hD5);
        check("R2 0xCD on pins", captured[5], 8'hB3);
        check("R1 bytes sent", captured.size(), 6);

        // Straight stream with gaps.
        captured.delete();
        send(8'h12, 0, 0, 3); send(8'hAA, 0, 0, 2); send(8'h99, 0, 0, 1);
        send(8'h55, 0, 0, 5); send(8'h66, 1, 0, 0);
        wait_idle();
        check("R3 0x12 on pins", captured[0], 8'h12);
        check("R8 sync after straight stream", sync_seen, 1);

        // Near miss: last byte wrong.
        send(8'hAA, 0, 1, 1); send(8'h99, 0, 1, 0); send(8'h55, 0, 1, 0); send(8'h67, 1, 1, 0);
        wait_idle();
        check("R8 near miss no sync", sync_seen, 0);

        // Sync word split across two streams.
        send(8'hAA, 0, 0, 0); send(8'h99, 0, 0, 0); send(8'h55, 1, 0, 0);
        wait_idle();
        send(8'h66, 1, 0, 0);
        wait_idle();
        check("R8 split across streams no sync", sync_seen, 0);
        check("R7 done after short stream", done, 1);

        // Long stream with random back-pressure and swap.
        for (int k = 0; k < 40; k++) begin
            send(8'($urandom), (k == 39), 1'($urandom), int'($urandom % 4));
        end
        wait_idle();
        check("R4 all bytes delivered", exp_q.size(), 0);
        check("R6 strobes released", cfg_cs_n, 1);
        summary();
    end
endmodule